// File: doc/BRIEF.md
# Timer Output Configuration Write Guard

This block holds the configuration fields that shape a timer's complementary outputs and decides, cycle by cycle, whether software writes to those fields take effect. The fields cover the dead-time count, the idle output levels, the break controls, the off-state selections, the output polarities and the compare-mode and preload controls. A two-bit protection level sits beside them. Software may set that level exactly once after reset. From then on it fixes a growing set of field groups against change until the next reset.

Writes arrive on a simple bus made of a strobe, a three-bit group code and a data word. A write to a frozen field is dropped without any indication, and the field keeps its value. Polarity and compare controls are frozen only for channels that are driven as outputs. The per-channel direction flags are read on the same clock edge as the write.

Top module: `tmr_cfg_guard`

## Requirements
- R1: After reset every configuration output and the protection level read zero.
- R2: The first write to group code 0 loads wr_data[1:0] into the protection level (0 open, 1 basic, 2 medium, 3 full). Every later write to group 0 is ignored until reset, and this includes the case where the first write was 0.
- R3: At level 0 a write to any group from 1 to 6 is visible on the outputs one cycle after the write edge.
- R4: At level 1 or higher, writes are ignored to the dead-time group (code 1, wr_data[7:0]), the idle-level group (code 2, bit 2c is the normal output and bit 2c+1 the complementary output of channel c) and the break group (code 3, bit 0 enable, bit 1 polarity, bit 2 automatic output enable).
- R5: At level 2 or higher, writes are ignored to the off-state group (code 4, bit 0 run-mode selection, bit 1 idle-mode selection).
- R6: At level 2 or higher, a write to the polarity group (code 5, same bit layout as the idle levels) leaves unchanged the bits of every channel whose ch_is_out flag is 1 at the write edge. Bits of input channels are still written.
- R7: At level 3, a write to the compare group (code 6, bits 4c+2..4c are the mode of channel c and bit 4c+3 its preload enable) leaves unchanged the fields of output channels and still updates input channels. Below level 3 all compare fields accept writes.
- R8: Group code 7 selects no field, and a write to it changes no output.
- R9: Reset clears the protection level and rearms it, so the first group-0 write after a reset is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_grp | input | 3 | Field-group code |
| wr_data | input | 8 | Write data |
| ch_is_out | input | 2 | Per-channel output-direction flag |
| lock_lvl | output | 2 | Current protection level |
| dead_time | output | 8 | Dead-time count |
| idle_lvl | output | 4 | Idle output levels, normal and complementary |
| brk_cfg | output | 3 | Break enable, break polarity, auto output enable |
| off_sel | output | 2 | Off-state selections for run and idle |
| out_pol | output | 4 | Output polarities, normal and complementary |
| oc_mode | output | 6 | Compare mode per channel |
| oc_pre | output | 2 | Compare preload enable per channel |

## Verification
The bench targets several failure cases. The first is a level 0 first write that must still consume the single permitted write; a design that treats 0 as "not yet written" would then accept a later level 3. The second is a mixed-direction polarity or compare write, where one channel must change and the other must hold; a design that applies the channel condition to the wrong bits, or to no bits, would let an output channel's value change or freeze an input channel's value. The bench also checks each level boundary: a design whose group comparison is off by one would freeze the off-state controls at level 1, or leave the compare controls writable at level 3. Finally, it checks that a reset rearms the lock.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

   typedef logic [1:0] lock_lvl_t;

   typedef enum logic [2:0] {
      GRP_LOCK  = 3'd0,
      GRP_DEAD  = 3'd1,
      GRP_IDLE  = 3'd2,
      GRP_BRK   = 3'd3,
      GRP_OFF   = 3'd4,
      GRP_POL   = 3'd5,
      GRP_CMP   = 3'd6,
      GRP_NONE  = 3'd7
   } grp_e;

   localparam lock_lvl_t LVL_OPEN  = 2'd0;
   localparam lock_lvl_t LVL_BASIC = 2'd1;
   localparam lock_lvl_t LVL_MID   = 2'd2;
   localparam lock_lvl_t LVL_FULL  = 2'd3;

endpackage

// File: rtl/cfg_field_reg.sv
module cfg_field_reg #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("cfg_field_reg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/cfg_lock_latch.sv
module cfg_lock_latch
   import cfg_lock_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hit,
   input  lock_lvl_t wr_lvl,
   output lock_lvl_t lvl
);
   logic used;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used <= 1'b0;
         lvl  <= LVL_OPEN;
      end else if (hit && !used) begin
         used <= 1'b1;
         lvl  <= wr_lvl;
      end
   end

   AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      used |=> used);                                             // R2
   AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      used |=> $stable(lvl));                                     // R2
   AST_LOCK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !used) |=> (lvl == $past(wr_lvl)));                 // R2
endmodule

// File: rtl/cfg_lock_gate.sv
module cfg_lock_gate
   import cfg_lock_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic              wr_en,
   input  grp_e              grp,
   input  lock_lvl_t         lvl,
   input  logic [NUM_CH-1:0] ch_is_out,
   output logic              lock_hit,
   output logic              wen_dead,
   output logic              wen_idle,
   output logic              wen_brk,
   output logic              wen_off,
   output logic [NUM_CH-1:0] wen_pol,
   output logic [NUM_CH-1:0] wen_cmp
);
   logic open_l1, open_l2, open_l3;

   always_comb begin
      open_l1  = (lvl == LVL_OPEN);
      open_l2  = (lvl == LVL_OPEN) || (lvl == LVL_BASIC);
      open_l3  = (lvl != LVL_FULL);
      lock_hit = wr_en && (grp == GRP_LOCK);
      wen_dead = wr_en && (grp == GRP_DEAD) && open_l1;
      wen_idle = wr_en && (grp == GRP_IDLE) && open_l1;
      wen_brk  = wr_en && (grp == GRP_BRK)  && open_l1;
      wen_off  = wr_en && (grp == GRP_OFF)  && open_l2;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_comb begin
         wen_pol[c] = wr_en && (grp == GRP_POL) && (open_l2 || !ch_is_out[c]);
         wen_cmp[c] = wr_en && (grp == GRP_CMP) && (open_l3 || !ch_is_out[c]);
      end
   end
endmodule

// File: rtl/tmr_cfg_guard.sv
module tmr_cfg_guard
   import cfg_lock_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DT_W   = 8,
   parameter int OCM_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [2:0]              wr_grp,
   input  logic [DATA_W-1:0]       wr_data,
   input  logic [NUM_CH-1:0]       ch_is_out,
   output logic [1:0]              lock_lvl,
   output logic [DT_W-1:0]         dead_time,
   output logic [2*NUM_CH-1:0]     idle_lvl,
   output logic [2:0]              brk_cfg,
   output logic [1:0]              off_sel,
   output logic [2*NUM_CH-1:0]     out_pol,
   output logic [OCM_W*NUM_CH-1:0] oc_mode,
   output logic [NUM_CH-1:0]       oc_pre
);
   localparam int PAIR_W = 2 * NUM_CH;
   localparam int CMP_ST = OCM_W + 1;
   localparam int CMP_W  = CMP_ST * NUM_CH;

   if (NUM_CH < 1)       begin : g_bad_ch  $error("NUM_CH must be at least 1"); end
   if (DATA_W < DT_W)    begin : g_bad_dt  $error("DATA_W narrower than DT_W"); end
   if (DATA_W < PAIR_W)  begin : g_bad_pr  $error("DATA_W narrower than pair fields"); end
   if (DATA_W < CMP_W)   begin : g_bad_cmp $error("DATA_W narrower than compare fields"); end
   if (DATA_W < 3)       begin : g_bad_brk $error("DATA_W narrower than break field"); end

   grp_e              grp;
   lock_lvl_t         lvl;
   logic              lock_hit, wen_dead, wen_idle, wen_brk, wen_off;
   logic [NUM_CH-1:0] wen_pol, wen_cmp;

   assign grp      = grp_e'(wr_grp);
   assign lock_lvl = lvl;

   cfg_lock_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (lock_hit),
      .wr_lvl (wr_data[1:0]),
      .lvl    (lvl)
   );

   cfg_lock_gate #(.NUM_CH(NUM_CH)) u_gate (
      .wr_en     (wr_en),
      .grp       (grp),
      .lvl       (lvl),
      .ch_is_out (ch_is_out),
      .lock_hit  (lock_hit),
      .wen_dead  (wen_dead),
      .wen_idle  (wen_idle),
      .wen_brk   (wen_brk),
      .wen_off   (wen_off),
      .wen_pol   (wen_pol),
      .wen_cmp   (wen_cmp)
   );

   cfg_field_reg #(.W(DT_W)) u_dead (
      .clk(clk), .rst_n(rst_n), .we(wen_dead), .d(wr_data[DT_W-1:0]), .q(dead_time));

   cfg_field_reg #(.W(PAIR_W)) u_idle (
      .clk(clk), .rst_n(rst_n), .we(wen_idle), .d(wr_data[PAIR_W-1:0]), .q(idle_lvl));

   cfg_field_reg #(.W(3)) u_brk (
      .clk(clk), .rst_n(rst_n), .we(wen_brk), .d(wr_data[2:0]), .q(brk_cfg));

   cfg_field_reg #(.W(2)) u_off (
      .clk(clk), .rst_n(rst_n), .we(wen_off), .d(wr_data[1:0]), .q(off_sel));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      cfg_field_reg #(.W(2)) u_pol (
         .clk(clk), .rst_n(rst_n), .we(wen_pol[c]),
         .d(wr_data[2*c +: 2]), .q(out_pol[2*c +: 2]));

      cfg_field_reg #(.W(OCM_W)) u_ocm (
         .clk(clk), .rst_n(rst_n), .we(wen_cmp[c]),
         .d(wr_data[CMP_ST*c +: OCM_W]), .q(oc_mode[OCM_W*c +: OCM_W]));

      cfg_field_reg #(.W(1)) u_ocp (
         .clk(clk), .rst_n(rst_n), .we(wen_cmp[c]),
         .d(wr_data[CMP_ST*c + OCM_W]), .q(oc_pre[c]));

      AST_POL_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl[1] && ch_is_out[c]) |=> $stable(out_pol[2*c +: 2]));        // R6
      AST_CMP_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         ((lvl == LVL_FULL) && ch_is_out[c]) |=>
            ($stable(oc_mode[OCM_W*c +: OCM_W]) && $stable(oc_pre[c])));   // R7
      AST_CMP_IN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && (wr_grp == 3'd6) && !ch_is_out[c]) |=>
            (oc_pre[c] == $past(wr_data[CMP_ST*c + OCM_W])));              // R7
   end

   AST_L1_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl != LVL_OPEN) |=>
         ($stable(dead_time) && $stable(idle_lvl) && $stable(brk_cfg)));   // R4
   AST_L2_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      lvl[1] |=> $stable(off_sel));                                        // R5
   AST_OPEN_DEAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_grp == 3'd1) && (lvl == LVL_OPEN)) |=>
         (dead_time == $past(wr_data[DT_W-1:0])));                         // R3
   AST_NONE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_grp == 3'd7)) |=>
         ($stable(dead_time) && $stable(out_pol) && $stable(oc_mode)
          && $stable(lock_lvl)));                                          // R8
endmodule

// File: tb/tb_tmr_cfg_guard.sv
module tb_tmr_cfg_guard;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [2:0] wr_grp;
   logic [7:0] wr_data;
   logic [1:0] ch_is_out;
   logic [1:0] lock_lvl;
   logic [7:0] dead_time;
   logic [3:0] idle_lvl;
   logic [2:0] brk_cfg;
   logic [1:0] off_sel;
   logic [3:0] out_pol;
   logic [5:0] oc_mode;
   logic [1:0] oc_pre;

   always #(CLK_PER/2) clk = ~clk;

   tmr_cfg_guard dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
      .wr_data(wr_data), .ch_is_out(ch_is_out), .lock_lvl(lock_lvl),
      .dead_time(dead_time), .idle_lvl(idle_lvl), .brk_cfg(brk_cfg),
      .off_sel(off_sel), .out_pol(out_pol), .oc_mode(oc_mode), .oc_pre(oc_pre));

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [1:0] m_lvl;  bit m_used;
   logic [7:0] m_dt;   logic [3:0] m_idle; logic [2:0] m_brk;
   logic [1:0] m_off;  logic [3:0] m_pol;  logic [5:0] m_ocm; logic [1:0] m_ocp;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_clear();
      m_lvl = 0; m_used = 0; m_dt = 0; m_idle = 0; m_brk = 0;
      m_off = 0; m_pol = 0; m_ocm = 0; m_ocp = 0;
   endtask

   function automatic bit lvl_ge(logic [1:0] l, int n);
      return int'(l) >= n;
   endfunction

   task automatic model_apply(logic [2:0] g, logic [7:0] d, logic [1:0] dir);
      case (g)
         3'd0: if (!m_used) begin m_lvl = d[1:0]; m_used = 1; end
         3'd1: if (!lvl_ge(m_lvl, 1)) m_dt = d;
         3'd2: if (!lvl_ge(m_lvl, 1)) m_idle = d[3:0];
         3'd3: if (!lvl_ge(m_lvl, 1)) m_brk = d[2:0];
         3'd4: if (!lvl_ge(m_lvl, 2)) m_off = d[1:0];
         3'd5: for (int c = 0; c < 2; c++)
                  if (!lvl_ge(m_lvl, 2) || !dir[c]) m_pol[2*c +: 2] = d[2*c +: 2];
         3'd6: for (int c = 0; c < 2; c++)
                  if (!lvl_ge(m_lvl, 3) || !dir[c]) begin
                     m_ocm[3*c +: 3] = d[4*c +: 3];
                     m_ocp[c] = d[4*c + 3];
                  end
         default: ;
      endcase
   endtask

   task automatic compare_all(string r_lock, string r_l1, string r_off,
                              string r_pol, string r_cmp);
      chk(r_lock, 32'(lock_lvl),  32'(m_lvl));
      chk(r_l1,   32'(dead_time), 32'(m_dt));
      chk(r_l1,   32'(idle_lvl),  32'(m_idle));
      chk(r_l1,   32'(brk_cfg),   32'(m_brk));
      chk(r_off,  32'(off_sel),   32'(m_off));
      chk(r_pol,  32'(out_pol),   32'(m_pol));
      chk(r_cmp,  32'(oc_mode),   32'(m_ocm));
      chk(r_cmp,  32'(oc_pre),    32'(m_ocp));
   endtask

   // Called at a negative edge; returns at the following negative edge.
   task automatic wr(logic [2:0] g, logic [7:0] d, logic [1:0] dir);
      wr_en = 1; wr_grp = g; wr_data = d; ch_is_out = dir;
      model_apply(g, d, dir);
      @(negedge clk);
      wr_en = 0;
      compare_all("R2", "R4", "R5", "R6", "R7");
   endtask

   task automatic do_reset();
      rst_n = 0; wr_en = 0; wr_grp = 0; wr_data = 0; ch_is_out = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      model_clear();
      @(negedge clk);
   endtask

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd1234);
      do_reset();
      compare_all("R1", "R1", "R1", "R1", "R1");

      // R3: open writes are visible one cycle later
      wr(3'd1, 8'hA5, 2'b00); chk("R3", 32'(dead_time), 32'hA5);
      wr(3'd4, 8'h02, 2'b11); chk("R3", 32'(off_sel), 32'h2);
      // R8: bit layout and the unused group
      wr(3'd6, 8'h3A, 2'b00); chk("R8", 32'(oc_mode), 32'h1A); chk("R8", 32'(oc_pre), 32'h1);
      wr(3'd7, 8'hFF, 2'b00); chk("R8", 32'(dead_time), 32'hA5);

      // R2: level 0 still consumes the only write
      wr(3'd0, 8'h00, 2'b00);
      wr(3'd0, 8'h03, 2'b00); chk("R2", 32'(lock_lvl), 32'h0);
      wr(3'd1, 8'h11, 2'b00); chk("R2", 32'(dead_time), 32'h11);

      // R9: reset rearms the lock; R6/R7 mixed-direction writes at full level
      do_reset();
      compare_all("R9", "R1", "R1", "R1", "R1");
      wr(3'd0, 8'h03, 2'b00); chk("R9", 32'(lock_lvl), 32'h3);
      wr(3'd5, 8'h0F, 2'b01); chk("R6", 32'(out_pol), 32'hC);
      wr(3'd6, 8'hFF, 2'b10); chk("R7", 32'(oc_mode), 32'h07); chk("R7", 32'(oc_pre), 32'h1);
      wr(3'd4, 8'h03, 2'b00); chk("R5", 32'(off_sel), 32'h0);

      // level 1 boundary: off-state and compare remain open
      do_reset();
      wr(3'd0, 8'h01, 2'b00);
      wr(3'd4, 8'h01, 2'b11); chk("R5", 32'(off_sel), 32'h1);
      wr(3'd2, 8'h05, 2'b00); chk("R4", 32'(idle_lvl), 32'h0);
      wr(3'd6, 8'h55, 2'b11); chk("R7", 32'(oc_mode), 32'h2D);

      // random epochs, one lock level each
      for (int ep = 0; ep < 8; ep++) begin
         do_reset();
         for (int s = 0; s < 150; s++) begin
            logic [2:0] g;
            if (s == 30) g = 3'd0;
            else if (s < 30) g = 3'($urandom_range(1, 7));
            else g = 3'($urandom_range(0, 7));
            if (s == 30) wr(g, 8'(ep % 4), 2'($urandom_range(0, 3)));
            else wr(g, 8'($urandom_range(0, 255)), 2'($urandom_range(0, 3)));
         end
      end

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
      end
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
      end
      $finish;
   end
endmodule